// File: doc/BRIEF.md
# Hardware Trap Priority and Vector Unit

This unit sits beside a CPU core and turns run-time exception requests into a single, ordered trap dispatch. Every hardware fault source (non-maskable interrupt, stack overflow, stack underflow and five class B faults) is latched into its own bit of a flag register. The register holds the bit until software clears it. Each cycle the unit picks the most urgent pending request. If that request belongs to a strictly higher priority class than the trap already in service, the unit pulses a take strobe. With the strobe it presents the trap number and the vector address, which is always the trap number times four. It also raises the in-service class.

A software trap instruction supplies its own 7-bit number. It is dispatched in any cycle in which no hardware trap wins. It leaves the in-service class unchanged, because the code it calls runs at the current CPU priority. A return-from-trap input drops the in-service class back to "none". Instruction decode and the stack bound comparators sit outside the unit and only deliver one-cycle request pulses.

Top module: `trap_unit`

## Requirements
- R1: On synchronous active-low reset `rst_n`, `take_trap`=0, `trap_vec`=0, `trap_num`=0, `act_class`=0 (none) and `trap_flags`=0.
- R2: A request pulse sets its flag bit at the next clock edge. Bit order of `trap_flags` is [0] NMI, [1] stack overflow, [2] stack underflow, [3+i] `fault_b_req[i]`. The bit stays set until a cycle with the matching `flag_clr` bit at 1, which clears it.
- R3: When a request and the clear of the same bit arrive in the same cycle, the bit stays set.
- R4: A software or watchdog reset request is taken at the next edge with vector 0x0000, number 0x00 and class 3.
- R5: Class A traps run at class 2. NMI uses vector 0x0008 / number 0x02, stack overflow uses 0x0010 / 0x04, and stack underflow uses 0x0018 / 0x06. Each is taken one edge after its flag is set.
- R6: Any set class B flag is taken with vector 0x0028, number 0x0A and class 1.
- R7: Among simultaneous candidates the order is reset request, NMI, stack overflow, stack underflow, then class B.
- R8: A hardware trap is taken only if its class is strictly greater than `act_class`. Otherwise it stays pending and no strobe is given.
- R9: `trap_ret` returns `act_class` to 0 when no hardware trap is taken in that cycle. Flags still set are then taken again.
- R10: A software trap request is taken when no hardware trap is taken that cycle. Its number is `sw_trap_num`, its vector is number×4 (0x0000–0x01FC), and `act_class` is unchanged.
- R11: `take_trap` is high for one cycle per dispatch. `trap_vec` and `trap_num` hold their values until the next dispatch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low hardware reset |
| soft_rst_req | input | 1 | Software reset request pulse |
| wdog_rst_req | input | 1 | Watchdog reset request pulse |
| nmi_req | input | 1 | Non-maskable interrupt event |
| stk_ovf_req | input | 1 | Stack overflow event |
| stk_unf_req | input | 1 | Stack underflow event |
| fault_b_req | input | NB (5) | Class B fault events |
| sw_trap_req | input | 1 | Software trap instruction request |
| sw_trap_num | input | 7 | Software trap number |
| flag_clr | input | NF (8) | Write-one-to-clear strobes for the flags |
| trap_ret | input | 1 | Return from trap service |
| trap_flags | output | NF (8) | Trap flag register |
| take_trap | output | 1 | One-cycle dispatch strobe |
| trap_vec | output | VEC_W (16) | Vector address of the last dispatch |
| trap_num | output | 7 | Trap number of the last dispatch |
| act_class | output | 2 | Class in service: 0 none, 1 B, 2 A, 3 reset |

## Verification
The bench goes after simultaneous sources. A wrong priority chain would dispatch stack overflow ahead of NMI, or a fault ahead of a reset request. It checks that a same-class or lower-class request during service stays pending with no strobe, where a non-strict compare would re-enter the handler. It checks that a flag left set after return is dispatched again, and that a set colliding with a clear keeps the flag; a clear-wins register would lose that event. A software trap during class A service must keep the class, and the largest number 0x7F must reach vector 0x1FC without truncation.

// File: rtl/trap_pkg.sv
// Shared types and constants of the trap unit.
// Assumes vectors are always the trap number shifted left by two.
package trap_pkg;

    localparam int TRAP_NUM_W = 7;

    // Flag bit positions; class B sources follow FLG_B_LO upward.
    localparam int FLG_NMI   = 0;
    localparam int FLG_STKOF = 1;
    localparam int FLG_STKUF = 2;
    localparam int FLG_B_LO  = 3;

    typedef enum logic [1:0] {
        CLS_NONE = 2'd0,
        CLS_B    = 2'd1,
        CLS_A    = 2'd2,
        CLS_RST  = 2'd3
    } trap_cls_e;

    localparam logic [TRAP_NUM_W-1:0] NUM_RST   = 7'h00;
    localparam logic [TRAP_NUM_W-1:0] NUM_NMI   = 7'h02;
    localparam logic [TRAP_NUM_W-1:0] NUM_STKOF = 7'h04;
    localparam logic [TRAP_NUM_W-1:0] NUM_STKUF = 7'h06;
    localparam logic [TRAP_NUM_W-1:0] NUM_B     = 7'h0A;

    typedef struct packed {
        logic                  hit;
        logic                  hw;
        trap_cls_e             cls;
        logic [TRAP_NUM_W-1:0] num;
    } trap_pick_t;

endpackage

// File: rtl/trap_flag_reg.sv
// Trap flag register: one sticky bit per hardware source.
// Assumes set and clear strobes are synchronous to clk; set beats clear.
module trap_flag_reg #(
    parameter int NF = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [NF-1:0] set_i,
    input  logic [NF-1:0] clr_i,
    output logic [NF-1:0] flags_o
);

    for (genvar i = 0; i < NF; i++) begin : g_bit
        // Hold the bit; a new event overrides a same-cycle clear.
        always_ff @(posedge clk) begin
            if (!rst_n)
                flags_o[i] <= 1'b0;
            else if (set_i[i])
                flags_o[i] <= 1'b1;
            else if (clr_i[i])
                flags_o[i] <= 1'b0;
        end

        p_flag_set_r2 : assert property (@(posedge clk) disable iff (!rst_n)
            set_i[i] |=> flags_o[i]);

        p_flag_clear_r2 : assert property (@(posedge clk) disable iff (!rst_n)
            (clr_i[i] && !set_i[i]) |=> !flags_o[i]);

        p_flag_hold_r2 : assert property (@(posedge clk) disable iff (!rst_n)
            (flags_o[i] && !clr_i[i]) |=> flags_o[i]);

        p_set_beats_clr_r3 : assert property (@(posedge clk) disable iff (!rst_n)
            (set_i[i] && clr_i[i]) |=> flags_o[i]);
    end

endmodule

// File: rtl/trap_prio_sel.sv
// Priority selector: finds the most urgent pending trap and decides
// whether it may preempt the class in service; otherwise offers a
// software trap. Purely combinational.
module trap_prio_sel
    import trap_pkg::*;
#(
    parameter int NB = 5,
    localparam int NF = FLG_B_LO + NB
) (
    input  logic                  rst_any_i,
    input  logic [NF-1:0]         flags_i,
    input  trap_cls_e             cur_cls_i,
    input  logic                  sw_req_i,
    input  logic [TRAP_NUM_W-1:0] sw_num_i,
    output trap_pick_t            pick_o
);

    trap_cls_e             cand_cls;
    logic [TRAP_NUM_W-1:0] cand_num;

    // Fixed priority chain over reset, class A and class B candidates.
    always_comb begin
        cand_cls = CLS_NONE;
        cand_num = '0;
        if (rst_any_i) begin
            cand_cls = CLS_RST;
            cand_num = NUM_RST;
        end else if (flags_i[FLG_NMI]) begin
            cand_cls = CLS_A;
            cand_num = NUM_NMI;
        end else if (flags_i[FLG_STKOF]) begin
            cand_cls = CLS_A;
            cand_num = NUM_STKOF;
        end else if (flags_i[FLG_STKUF]) begin
            cand_cls = CLS_A;
            cand_num = NUM_STKUF;
        end else if (|flags_i[NF-1:FLG_B_LO]) begin
            cand_cls = CLS_B;
            cand_num = NUM_B;
        end
    end

    // Strict-preemption gate, then software trap fallback.
    always_comb begin
        pick_o = '{hit: 1'b0, hw: 1'b0, cls: cur_cls_i, num: '0};
        if (cand_cls > cur_cls_i) begin
            pick_o.hit = 1'b1;
            pick_o.hw  = 1'b1;
            pick_o.cls = cand_cls;
            pick_o.num = cand_num;
        end else if (sw_req_i) begin
            pick_o.hit = 1'b1;
            pick_o.num = sw_num_i;
        end
    end

endmodule

// File: rtl/trap_unit.sv
// Hardware trap priority and vector unit (top).
// Latches fault events into flags, dispatches the most urgent trap that
// outranks the class in service, and registers vector, number and class.
// Assumes request inputs are single-cycle pulses from synchronous logic.
module trap_unit
    import trap_pkg::*;
#(
    parameter int NB    = 5,
    parameter int VEC_W = 16,
    localparam int NF   = FLG_B_LO + NB
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  soft_rst_req,
    input  logic                  wdog_rst_req,
    input  logic                  nmi_req,
    input  logic                  stk_ovf_req,
    input  logic                  stk_unf_req,
    input  logic [NB-1:0]         fault_b_req,
    input  logic                  sw_trap_req,
    input  logic [TRAP_NUM_W-1:0] sw_trap_num,
    input  logic [NF-1:0]         flag_clr,
    input  logic                  trap_ret,
    output logic [NF-1:0]         trap_flags,
    output logic                  take_trap,
    output logic [VEC_W-1:0]      trap_vec,
    output logic [TRAP_NUM_W-1:0] trap_num,
    output logic [1:0]            act_class
);

    localparam int PAD_W = VEC_W - TRAP_NUM_W - 2;

    logic [NF-1:0]         set_vec;
    trap_pick_t            pick;
    trap_cls_e             cls_q;
    logic                  take_q;
    logic [TRAP_NUM_W-1:0] num_q;

    assign set_vec = {fault_b_req, stk_unf_req, stk_ovf_req, nmi_req};

    trap_flag_reg #(.NF(NF)) i_flags (
        .clk     (clk),
        .rst_n   (rst_n),
        .set_i   (set_vec),
        .clr_i   (flag_clr),
        .flags_o (trap_flags)
    );

    trap_prio_sel #(.NB(NB)) i_sel (
        .rst_any_i (soft_rst_req | wdog_rst_req),
        .flags_i   (trap_flags),
        .cur_cls_i (cls_q),
        .sw_req_i  (sw_trap_req),
        .sw_num_i  (sw_trap_num),
        .pick_o    (pick)
    );

    // Register the dispatch strobe and hold number until the next dispatch.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            take_q <= 1'b0;
            num_q  <= '0;
        end else begin
            take_q <= pick.hit;
            if (pick.hit)
                num_q <= pick.num;
        end
    end

    // Track the class in service; a hardware dispatch beats a return.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cls_q <= CLS_NONE;
        else if (pick.hw)
            cls_q <= pick.cls;
        else if (trap_ret)
            cls_q <= CLS_NONE;
    end

    assign take_trap = take_q;
    assign trap_num  = num_q;
    assign trap_vec  = {{PAD_W{1'b0}}, num_q, 2'b00};
    assign act_class = cls_q;

    p_rise_needs_take_r8 : assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && act_class > $past(act_class)) |-> take_trap);

    p_hold_between_r11 : assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !take_trap) |-> ($stable(trap_vec) && $stable(trap_num)));

    p_reset_vec_r4 : assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && take_trap && act_class == 2'd3 && $past(act_class) != 2'd3)
        |-> (trap_vec == '0 && trap_num == '0));

    p_class_a_vec_r5 : assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && take_trap && act_class == 2'd2 && $past(act_class) != 2'd2)
        |-> (trap_num == 7'h02 || trap_num == 7'h04 || trap_num == 7'h06));

    p_class_b_vec_r6 : assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && take_trap && act_class == 2'd1 && $past(act_class) != 2'd1)
        |-> (trap_vec == 16'h0028));

    p_sw_vector_r10 : assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && take_trap && $past(sw_trap_req) && !$past(trap_ret)
         && act_class == $past(act_class))
        |-> (trap_num == $past(sw_trap_num)));

    p_ret_drops_r9 : assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(trap_ret) && act_class == $past(act_class))
        |-> act_class == 2'd0);

endmodule

// File: tb/test_trap_unit.sv
module test_trap_unit;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        soft_rst_req, wdog_rst_req, nmi_req, stk_ovf_req, stk_unf_req;
    logic [4:0]  fault_b_req;
    logic        sw_trap_req;
    logic [6:0]  sw_trap_num;
    logic [7:0]  flag_clr;
    logic        trap_ret;
    logic [7:0]  trap_flags;
    logic        take_trap;
    logic [15:0] trap_vec;
    logic [6:0]  trap_num;
    logic [1:0]  act_class;

    int n_chk = 0;
    int n_bad = 0;

    always #5 clk = ~clk;

    trap_unit i_trap_unit (
        .clk(clk), .rst_n(rst_n),
        .soft_rst_req(soft_rst_req), .wdog_rst_req(wdog_rst_req),
        .nmi_req(nmi_req), .stk_ovf_req(stk_ovf_req), .stk_unf_req(stk_unf_req),
        .fault_b_req(fault_b_req), .sw_trap_req(sw_trap_req),
        .sw_trap_num(sw_trap_num), .flag_clr(flag_clr), .trap_ret(trap_ret),
        .trap_flags(trap_flags), .take_trap(take_trap), .trap_vec(trap_vec),
        .trap_num(trap_num), .act_class(act_class)
    );

    typedef struct packed {
        logic [1:0]  rs;     // {wdog, soft}
        logic        nmi;
        logic        ovf;
        logic        unf;
        logic [4:0]  b;
        logic        sw;
        logic [6:0]  swn;
        logic [1:0]  lat;    // edges until dispatch
        logic [15:0] evec;
        logic [6:0]  enm;
        logic [1:0]  ecls;
        logic [3:0]  rq;
    } vec_t;

    localparam int NV = 13;
    localparam vec_t TBL [NV] = '{
        '{2'b01, 1'b0, 1'b0, 1'b0, 5'h00, 1'b0, 7'h00, 2'd1, 16'h0000, 7'h00, 2'd3, 4'd4},  // R4 soft
        '{2'b10, 1'b0, 1'b0, 1'b0, 5'h00, 1'b0, 7'h00, 2'd1, 16'h0000, 7'h00, 2'd3, 4'd4},  // R4 watchdog
        '{2'b00, 1'b1, 1'b0, 1'b0, 5'h00, 1'b0, 7'h00, 2'd2, 16'h0008, 7'h02, 2'd2, 4'd5},  // R5 NMI
        '{2'b00, 1'b0, 1'b1, 1'b0, 5'h00, 1'b0, 7'h00, 2'd2, 16'h0010, 7'h04, 2'd2, 4'd5},  // R5 overflow
        '{2'b00, 1'b0, 1'b0, 1'b1, 5'h00, 1'b0, 7'h00, 2'd2, 16'h0018, 7'h06, 2'd2, 4'd5},  // R5 underflow
        '{2'b00, 1'b0, 1'b0, 1'b0, 5'h01, 1'b0, 7'h00, 2'd2, 16'h0028, 7'h0A, 2'd1, 4'd6},  // R6 lowest B
        '{2'b00, 1'b0, 1'b0, 1'b0, 5'h10, 1'b0, 7'h00, 2'd2, 16'h0028, 7'h0A, 2'd1, 4'd6},  // R6 highest B
        '{2'b00, 1'b0, 1'b0, 1'b0, 5'h00, 1'b1, 7'h7F, 2'd1, 16'h01FC, 7'h7F, 2'd0, 4'd10}, // R10 max
        '{2'b00, 1'b0, 1'b0, 1'b0, 5'h00, 1'b1, 7'h00, 2'd1, 16'h0000, 7'h00, 2'd0, 4'd10}, // R10 zero
        '{2'b00, 1'b1, 1'b1, 1'b0, 5'h04, 1'b0, 7'h00, 2'd2, 16'h0008, 7'h02, 2'd2, 4'd7},  // R7 NMI first
        '{2'b00, 1'b0, 1'b0, 1'b1, 5'h08, 1'b0, 7'h00, 2'd2, 16'h0018, 7'h06, 2'd2, 4'd7},  // R7 A over B
        '{2'b01, 1'b1, 1'b0, 1'b0, 5'h00, 1'b0, 7'h00, 2'd1, 16'h0000, 7'h00, 2'd3, 4'd7},  // R7 reset first
        '{2'b00, 1'b1, 1'b0, 1'b0, 5'h00, 1'b1, 7'h05, 2'd1, 16'h0014, 7'h05, 2'd0, 4'd10}  // R10 beats late flag
    };

    task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", tag, got, exp);
        end
    endtask

    task automatic idle();
        soft_rst_req = 1'b0; wdog_rst_req = 1'b0; nmi_req = 1'b0;
        stk_ovf_req = 1'b0; stk_unf_req = 1'b0; fault_b_req = '0;
        sw_trap_req = 1'b0; sw_trap_num = '0; flag_clr = '0; trap_ret = 1'b0;
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic summary();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual hung expected finish");
        summary();
    end

    initial begin
        idle();
        rst_n = 1'b0;
        @(negedge clk);
        tick(); tick();
        rst_n = 1'b1;

        // R1 reset state
        chk("R1 take", take_trap, 0);
        chk("R1 vec", trap_vec, 0);
        chk("R1 num", trap_num, 0);
        chk("R1 class", act_class, 0);
        chk("R1 flags", trap_flags, 0);

        // Vector table walk
        for (int k = 0; k < NV; k++) begin
            soft_rst_req = TBL[k].rs[0]; wdog_rst_req = TBL[k].rs[1];
            nmi_req = TBL[k].nmi; stk_ovf_req = TBL[k].ovf; stk_unf_req = TBL[k].unf;
            fault_b_req = TBL[k].b; sw_trap_req = TBL[k].sw; sw_trap_num = TBL[k].swn;
            tick();
            idle();
            if (TBL[k].lat == 2'd2) tick();
            chk($sformatf("R%0d row %0d take", TBL[k].rq, k), take_trap, 1);
            chk($sformatf("R%0d row %0d vec", TBL[k].rq, k), trap_vec, TBL[k].evec);
            chk($sformatf("R%0d row %0d num", TBL[k].rq, k), trap_num, TBL[k].enm);
            chk($sformatf("R%0d row %0d class", TBL[k].rq, k), act_class, TBL[k].ecls);
            flag_clr = '1; trap_ret = 1'b1;
            tick(); tick();
            idle();
            tick();
        end

        // R2 flag set, R5 dispatch, R11 single pulse and hold
        nmi_req = 1'b1; tick(); idle();
        chk("R2 flag set", trap_flags, 8'h01);
        chk("R5 not yet", take_trap, 0);
        tick();
        chk("R5 take", take_trap, 1);
        chk("R5 vec", trap_vec, 16'h0008);
        tick();
        chk("R11 pulse ends", take_trap, 0);
        chk("R11 vec held", trap_vec, 16'h0008);
        chk("R2 flag sticky", trap_flags, 8'h01);

        // R8 same and lower class stay pending during class A service
        stk_ovf_req = 1'b1; tick(); idle(); tick();
        chk("R8 same class no take", take_trap, 0);
        chk("R8 class kept", act_class, 2);
        fault_b_req = 5'h04; tick(); idle(); tick();
        chk("R8 lower class no take", take_trap, 0);
        chk("R8 flags pending", trap_flags, 8'h23);

        // R10 software trap during service keeps class
        sw_trap_req = 1'b1; sw_trap_num = 7'h11; tick(); idle();
        chk("R10 sw take", take_trap, 1);
        chk("R10 sw vec", trap_vec, 16'h0044);
        chk("R10 class kept", act_class, 2);
        tick();

        // R8 higher class preempts
        soft_rst_req = 1'b1; tick(); idle();
        chk("R8 reset preempts", take_trap, 1);
        chk("R8 reset vec", trap_vec, 16'h0000);
        chk("R8 reset class", act_class, 3);

        // R9 return drops class, pending flag retaken
        trap_ret = 1'b1; tick(); idle();
        chk("R9 class none", act_class, 0);
        chk("R9 no take on ret", take_trap, 0);
        tick();
        chk("R9 retake", take_trap, 1);
        chk("R9 retake vec", trap_vec, 16'h0008);
        chk("R9 retake class", act_class, 2);

        // R3 set beats clear; R2 clear alone
        stk_ovf_req = 1'b1; flag_clr = 8'h02; tick(); idle();
        chk("R3 set wins", trap_flags & 8'h02, 8'h02);
        flag_clr = 8'h01; tick(); idle();
        chk("R2 clear", trap_flags, 8'h22);
        chk("R8 no take during clears", take_trap, 0);

        // R1 hardware reset mid-run
        rst_n = 1'b0; tick(); rst_n = 1'b1;
        chk("R1 flags after reset", trap_flags, 0);
        chk("R1 class after reset", act_class, 0);
        chk("R1 vec after reset", trap_vec, 0);
        chk("R1 take after reset", take_trap, 0);

        summary();
    end

endmodule